// File: doc/BRIEF.md
# Wavefront Instruction Line Buffer

This block sits between one wavefront's instruction fetch and the instruction decoder. It holds a small ring of cache-line slots. It tells the fetch logic which line-aligned address to request next. It reserves a slot when that request goes out, and it fills the slot when the line returns. From the filled lines it delivers raw instruction words to the decoder.

The decoder examines the presented 64-bit word and answers with the instruction's length (4 or 8 bytes). On a handshake the buffer advances its read position by that length. An instruction that runs past the last slot is rebuilt from the final 32-bit word of the ring and the first word at its start.

Slots are recycled in the order they were filled. The oldest line is dropped only when the ring is full and the program counter has reached a later buffered line. A branch flush empties the ring and discards replies still in flight. The first fetch after a flush starts decoding at the program counter's word offset within its line.

Top module: `ilb_line_buffer`

## Requirements
- R1: After reset every slot is free, `fetch_ok` is 1, `inst_valid` is 0 and `fetch_addr` is `pc` rounded down to a multiple of LINE_BYTES.
- R2: A `fetch_issue` pulse while `fetch_ok` is 1 reserves one slot for `fetch_addr`. A reserved slot supplies no instruction data. `fetch_ok` drops once all DEPTH slots are reserved or buffered. A `fetch_issue` while `fetch_ok` is 0 has no effect.
- R3: While any slot is reserved or buffered, `fetch_addr` equals the most recently issued line address plus LINE_BYTES. When no slot is reserved or buffered, it is `pc` rounded down to a line boundary.
- R4: `flush` returns every slot to free in the next cycle and drops `inst_valid`. A reply to a request issued before the flush is then ignored.
- R5: The first issue into an empty ring sets the read position. After a flush it goes to the word offset of `pc` within its line (`pc[OFF-1:2]`). Otherwise, after reset, it goes to the start of the line.
- R6: A line is released only when no slot is free. If the line holding `pc` is reserved, nothing is released. If it is buffered and is not the oldest buffered line, the oldest line is freed, which raises `fetch_ok` in the next cycle.
- R7: `inst_valid` is 1 exactly when at least 8 unread bytes exist. Unread bytes run from the read position to the end of the newest buffered line, counted modulo the ring size. The count is 0 when no line is buffered.
- R8: On `inst_valid` and `inst_ready` the read position advances by 8 bytes if `inst_is64` is 1, otherwise by 4. While `inst_ready` is 0 the position and `inst_word` hold.
- R9: `inst_word[31:0]` is the 32-bit word at the read position and `inst_word[63:32]` is the word after it. When the read position is the ring's last word, the upper half comes from the ring's first word.
- R10: A reply (`ret_valid`, `ret_addr`, `ret_data`) whose line matches a reserved slot writes the whole line into that slot and marks it buffered. Bytes sit little-endian, so byte k of the line is `ret_data[8k+7:8k]`. A reply matching no reserved slot is ignored.
- R11: The read position wraps from the ring's end to its start, including across a split 8-byte instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pc | input | ADDR_W | Wavefront program counter (4-byte aligned) |
| flush | input | 1 | Branch flush: empty the ring and arm the restart offset |
| fetch_addr | output | ADDR_W | Next line-aligned address to request |
| fetch_ok | output | 1 | At least one slot is free |
| fetch_issue | input | 1 | A request for `fetch_addr` was sent |
| ret_valid | input | 1 | Line reply strobe |
| ret_addr | input | ADDR_W | Address of the returned line |
| ret_data | input | LINE_BYTES*8 | Returned line, byte 0 in bits 7:0 |
| inst_valid | output | 1 | `inst_word` holds at least 8 unread bytes |
| inst_ready | input | 1 | Decoder accepts the presented instruction |
| inst_is64 | input | 1 | Decoder length answer: 1 for 8 bytes, 0 for 4 |
| inst_word | output | 64 | Raw instruction bytes at the read position |

## Verification
The bench fills the ring in address order and answers replies in several patterns: an unmatched reply, one line at a time, and several lines in a row after a release. This separates reserved slots from buffered ones and shows that stray replies are ignored. Decoder answers mix 4- and 8-byte lengths. Some steps leave exactly one word unread, and one 8-byte instruction straddles the ring end, which separates the modular unread count and the split read from a plain linear read. The program counter is placed in the oldest buffered line, in a reserved line and in a newer buffered line, so each branch of the release rule shows on `fetch_ok`. A flush issued at an unaligned program counter checks that in-flight replies are dropped and that decoding restarts at the program counter's word offset.

// File: rtl/ilb_pkg.sv
package ilb_pkg;

  // Advance a ring index by n positions, with n never above total.
  function automatic int ring_add(input int v, input int n, input int total);
    int s;
    s = v + n;
    if (s >= total) s = s - total;
    return s;
  endfunction

  // Distance from 'from_w' forward to 'to_w' on a ring of 'total' entries.
  function automatic int ring_gap(input int to_w, input int from_w, input int total);
    int d;
    d = to_w - from_w;
    if (d < 0) d = d + total;
    return d;
  endfunction

endpackage

// File: rtl/ilb_slots.sv
module ilb_slots #(
  parameter int DEPTH     = 4,
  parameter int TAG_W     = 28,
  parameter int LINE_BITS = 128,
  parameter int SLOT_W    = 2
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                clr,
  input  logic                                alloc_en,
  input  logic [SLOT_W-1:0]                   alloc_idx,
  input  logic [TAG_W-1:0]                    alloc_tag,
  input  logic                                ret_valid,
  input  logic [TAG_W-1:0]                    ret_tag,
  input  logic [LINE_BITS-1:0]                ret_data,
  input  logic                                rel_en,
  input  logic [SLOT_W-1:0]                   rel_idx,
  output logic [DEPTH-1:0]                    resv,
  output logic [DEPTH-1:0]                    bufd,
  output logic [DEPTH-1:0][TAG_W-1:0]         tags,
  output logic [DEPTH-1:0][LINE_BITS-1:0]     data,
  output logic                                ret_hit
);

  logic [DEPTH-1:0] hits;

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic                 r_q;
    logic                 b_q;
    logic [TAG_W-1:0]     t_q;
    logic [LINE_BITS-1:0] d_q;

    assign hits[i] = ret_valid && r_q && (t_q == ret_tag);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        r_q <= 1'b0;
        b_q <= 1'b0;
        t_q <= '0;
      end else if (clr) begin
        r_q <= 1'b0;
        b_q <= 1'b0;
      end else begin
        if (alloc_en && alloc_idx == SLOT_W'(i)) begin
          r_q <= 1'b1;
          t_q <= alloc_tag;
        end
        if (hits[i]) begin
          r_q <= 1'b0;
          b_q <= 1'b1;
        end
        if (rel_en && rel_idx == SLOT_W'(i)) b_q <= 1'b0;
      end
    end

    always_ff @(posedge clk) begin
      if (hits[i] && !clr) d_q <= ret_data;
    end

    assign resv[i] = r_q;
    assign bufd[i] = b_q;
    assign tags[i] = t_q;
    assign data[i] = d_q;
  end

  assign ret_hit = |hits;

  // R2: a reservation only ever lands on a free slot
  assert_alloc_free_R2: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_en |-> (!resv[alloc_idx] && !bufd[alloc_idx]));

  // R4: flush leaves no slot reserved or buffered
  assert_flush_empties_R4: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (resv == '0 && bufd == '0));

  // R10: a matching reply turns its slot buffered
  assert_reply_fills_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_hit && !clr) |=> ((bufd & $past(hits)) == $past(hits)));

  // R10: an unmatched reply leaves buffered state untouched
  assert_stray_reply_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid && !ret_hit && !clr && !rel_en) |=> $stable(bufd));

endmodule

// File: rtl/ilb_reader.sv
module ilb_reader
  import ilb_pkg::*;
#(
  parameter int DEPTH     = 4,
  parameter int WPL       = 4,
  parameter int SLOT_W    = 2,
  parameter int WOFF_W    = 2,
  parameter int LINE_BITS = 128
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            clr,
  input  logic                            load_en,
  input  logic [WOFF_W-1:0]               load_word,
  input  logic [DEPTH-1:0]                bufd,
  input  logic [SLOT_W-1:0]               head,
  input  logic [DEPTH-1:0][LINE_BITS-1:0] data,
  input  logic                            inst_ready,
  input  logic                            inst_is64,
  output logic                            inst_valid,
  output logic [63:0]                     inst_word,
  output logic                            split
);

  localparam int BUF_WORDS = DEPTH * WPL;
  localparam int RP_W      = SLOT_W + WOFF_W;

  logic [RP_W-1:0]   rd_q;
  logic [RP_W-1:0]   hi_ptr;
  logic [SLOT_W-1:0] newest;
  logic              have;
  logic              take;
  int                unread;

  // Newest buffered line, found by walking the ring from its oldest slot
  always_comb begin
    have   = 1'b0;
    newest = '0;
    for (int k = 0; k < DEPTH; k++) begin
      logic [SLOT_W-1:0] idx;
      idx = SLOT_W'(ring_add(int'(head), k, DEPTH));
      if (bufd[idx]) begin
        have   = 1'b1;
        newest = idx;
      end
    end
  end

  assign unread = have ? ring_gap((int'(newest) + 1) * WPL, int'(rd_q), BUF_WORDS) : 0;

  assign inst_valid = have && (unread >= 2);
  assign take       = inst_valid && inst_ready;
  assign split      = (rd_q == RP_W'(BUF_WORDS - 1));
  assign hi_ptr     = RP_W'(ring_add(int'(rd_q), 1, BUF_WORDS));

  assign inst_word = {
    data[hi_ptr[RP_W-1:WOFF_W]][{hi_ptr[WOFF_W-1:0], 5'b0} +: 32],
    data[rd_q[RP_W-1:WOFF_W]][{rd_q[WOFF_W-1:0], 5'b0} +: 32]
  };

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_q <= '0;
    end else if (clr) begin
      rd_q <= '0;
    end else if (load_en) begin
      rd_q <= RP_W'(load_word);
    end else if (take) begin
      rd_q <= RP_W'(ring_add(int'(rd_q), inst_is64 ? 2 : 1, BUF_WORDS));
    end
  end

  // R7: nothing is offered while no line is buffered
  assert_empty_no_inst_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bufd == '0) |-> !inst_valid);

  // R8: an unaccepted instruction is presented again unchanged
  assert_hold_word_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (inst_valid && !inst_ready && !clr && !load_en) |=> $stable(inst_word));

  // R11: a split read leaves the pointer at the ring start
  assert_split_wraps_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (take && split && !clr) |=> (rd_q < RP_W'(2)));

endmodule

// File: rtl/ilb_line_buffer.sv
module ilb_line_buffer
  import ilb_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 16,
  parameter int DEPTH      = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       pc,
  input  logic                    flush,
  output logic [ADDR_W-1:0]       fetch_addr,
  output logic                    fetch_ok,
  input  logic                    fetch_issue,
  input  logic                    ret_valid,
  input  logic [ADDR_W-1:0]       ret_addr,
  input  logic [LINE_BYTES*8-1:0] ret_data,
  output logic                    inst_valid,
  input  logic                    inst_ready,
  input  logic                    inst_is64,
  output logic [63:0]             inst_word
);

  localparam int OFF_W     = $clog2(LINE_BYTES);
  localparam int WOFF_W    = OFF_W - 2;
  localparam int WPL       = LINE_BYTES / 4;
  localparam int TAG_W     = ADDR_W - OFF_W;
  localparam int SLOT_W    = $clog2(DEPTH);
  localparam int LINE_BITS = LINE_BYTES * 8;

  logic [DEPTH-1:0]                resv;
  logic [DEPTH-1:0]                bufd;
  logic [DEPTH-1:0][TAG_W-1:0]     tags;
  logic [DEPTH-1:0][LINE_BITS-1:0] data;
  logic                            ret_hit;

  logic [SLOT_W-1:0] head_q;
  logic [SLOT_W-1:0] tail_q;
  logic [TAG_W-1:0]  last_line_q;
  logic              restart_q;

  logic [TAG_W-1:0]  pc_tag;
  logic              occupied;
  logic              full;
  logic              issue;
  logic              rel;
  logic              pc_resv;
  logic              pc_hit;
  logic [SLOT_W-1:0] pc_idx;
  logic              load_en;
  logic [WOFF_W-1:0] load_word;
  logic              split;
  logic              unused_low;

  assign unused_low = ^{pc[1:0], ret_addr[OFF_W-1:0], ret_hit, split};

  assign pc_tag     = pc[ADDR_W-1:OFF_W];
  assign occupied   = |(resv | bufd);
  assign full       = &(resv | bufd);
  assign fetch_ok   = !full;
  assign fetch_addr = {(occupied ? last_line_q + TAG_W'(1) : pc_tag), {OFF_W{1'b0}}};
  assign issue      = fetch_issue && fetch_ok && !flush;

  // Where the program counter's line sits in the ring
  always_comb begin
    pc_resv = 1'b0;
    pc_hit  = 1'b0;
    pc_idx  = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (resv[i] && tags[i] == pc_tag) pc_resv = 1'b1;
      if (bufd[i] && tags[i] == pc_tag) begin
        pc_hit = 1'b1;
        pc_idx = SLOT_W'(i);
      end
    end
  end

  assign rel       = full && !pc_resv && pc_hit && (pc_idx != head_q) && !flush;
  assign load_en   = issue && !occupied;
  assign load_word = restart_q ? pc[OFF_W-1:2] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q      <= '0;
      tail_q      <= '0;
      last_line_q <= '0;
      restart_q   <= 1'b0;
    end else if (flush) begin
      head_q    <= '0;
      tail_q    <= '0;
      restart_q <= 1'b1;
    end else begin
      if (issue) begin
        tail_q      <= SLOT_W'(ring_add(int'(tail_q), 1, DEPTH));
        last_line_q <= pc_tag_or_next();
        if (!occupied) restart_q <= 1'b0;
      end
      if (rel) head_q <= SLOT_W'(ring_add(int'(head_q), 1, DEPTH));
    end
  end

  function automatic logic [TAG_W-1:0] pc_tag_or_next();
    return fetch_addr[ADDR_W-1:OFF_W];
  endfunction

  ilb_slots #(
    .DEPTH(DEPTH), .TAG_W(TAG_W), .LINE_BITS(LINE_BITS), .SLOT_W(SLOT_W)
  ) u_slots (
    .clk(clk), .rst_n(rst_n), .clr(flush),
    .alloc_en(issue), .alloc_idx(tail_q), .alloc_tag(fetch_addr[ADDR_W-1:OFF_W]),
    .ret_valid(ret_valid), .ret_tag(ret_addr[ADDR_W-1:OFF_W]), .ret_data(ret_data),
    .rel_en(rel), .rel_idx(head_q),
    .resv(resv), .bufd(bufd), .tags(tags), .data(data), .ret_hit(ret_hit)
  );

  ilb_reader #(
    .DEPTH(DEPTH), .WPL(WPL), .SLOT_W(SLOT_W), .WOFF_W(WOFF_W), .LINE_BITS(LINE_BITS)
  ) u_reader (
    .clk(clk), .rst_n(rst_n), .clr(flush),
    .load_en(load_en), .load_word(load_word),
    .bufd(bufd), .head(head_q), .data(data),
    .inst_ready(inst_ready), .inst_is64(inst_is64),
    .inst_valid(inst_valid), .inst_word(inst_word), .split(split)
  );

  // R6: a release always hands a free slot back to fetch
  assert_release_frees_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rel |=> fetch_ok);

  // R3: each issue moves the next request one line forward
  assert_next_line_R3: assert property (@(posedge clk) disable iff (!rst_n)
    issue |=> (fetch_addr == $past(fetch_addr) + ADDR_W'(LINE_BYTES)));

  // R4: a flush withdraws any offered instruction
  assert_flush_quiets_R4: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !inst_valid);

endmodule

// File: tb/ilb_line_buffer_tb.sv
module ilb_line_buffer_tb;

  localparam int AW = 32;
  localparam int LB = 16;
  localparam int DP = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] pc;
  logic          flush;
  logic [AW-1:0] fetch_addr;
  logic          fetch_ok;
  logic          fetch_issue;
  logic          ret_valid;
  logic [AW-1:0] ret_addr;
  logic [LB*8-1:0] ret_data;
  logic          inst_valid;
  logic          inst_ready;
  logic          inst_is64;
  logic [63:0]   inst_word;

  int n_chk  = 0;
  int n_fail = 0;
  logic [AW-1:0] ra;

  always #10 clk = ~clk;

  ilb_line_buffer #(.ADDR_W(AW), .LINE_BYTES(LB), .DEPTH(DP)) u_dut (
    .clk(clk), .rst_n(rst_n), .pc(pc), .flush(flush),
    .fetch_addr(fetch_addr), .fetch_ok(fetch_ok), .fetch_issue(fetch_issue),
    .ret_valid(ret_valid), .ret_addr(ret_addr), .ret_data(ret_data),
    .inst_valid(inst_valid), .inst_ready(inst_ready), .inst_is64(inst_is64),
    .inst_word(inst_word)
  );

  function automatic logic [31:0] mword(input logic [AW-1:0] a);
    return {a[15:0] ^ 16'hBEEF, a[15:0]};
  endfunction

  function automatic logic [LB*8-1:0] line_of(input logic [AW-1:0] a);
    logic [LB*8-1:0] d;
    for (int i = 0; i < LB / 4; i++) d[32*i +: 32] = mword(a + AW'(4 * i));
    return d;
  endfunction

  function automatic logic [63:0] inst_at(input logic [AW-1:0] a);
    return {mword(a + 32'd4), mword(a)};
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    #1;
  endtask

  task automatic issue_one();
    fetch_issue = 1'b1;
    tick();
    fetch_issue = 1'b0;
  endtask

  task automatic reply(input logic [AW-1:0] a);
    ret_valid = 1'b1;
    ret_addr  = a;
    ret_data  = line_of(a);
    tick();
    ret_valid = 1'b0;
  endtask

  task automatic take_one(input logic is64, input string req);
    check(req, {63'd0, inst_valid}, 64'd1);
    check(req, inst_word, inst_at(ra));
    inst_ready = 1'b1;
    inst_is64  = is64;
    tick();
    inst_ready = 1'b0;
    ra = ra + (is64 ? 32'd8 : 32'd4);
  endtask

  // R1: reset state
  task automatic t_reset();
    check("R1 fetch_ok", {63'd0, fetch_ok}, 64'd1);
    check("R1 inst_valid", {63'd0, inst_valid}, 64'd0);
    check("R1 R3 fetch_addr", {32'd0, fetch_addr}, 64'h100);
  endtask

  // R2 R3: fill every slot in address order
  task automatic t_fill();
    for (int k = 0; k < DP; k++) begin
      check("R3 next line", {32'd0, fetch_addr}, 64'h100 + 64'(16 * k));
      issue_one();
    end
    check("R2 full", {63'd0, fetch_ok}, 64'd0);
    check("R2 reserved not readable", {63'd0, inst_valid}, 64'd0);
    issue_one();
    check("R2 issue while full ignored", {32'd0, fetch_addr}, 64'h140);
  endtask

  // R10 R5 R7 R8 R9: replies and first reads
  task automatic t_replies();
    reply(32'h500);
    check("R10 stray reply", {63'd0, inst_valid}, 64'd0);
    reply(32'h100);
    ra = 32'h100;
    check("R5 start of line without flush", inst_word, inst_at(32'h100));
    check("R6 pc in oldest keeps ring full", {63'd0, fetch_ok}, 64'd0);
    inst_is64 = 1'b1;
    tick();
    check("R8 hold while not ready", inst_word, inst_at(32'h100));
    take_one(1'b1, "R8 R9 64-bit step");
    take_one(1'b0, "R8 R9 32-bit step");
    check("R7 one word left", {63'd0, inst_valid}, 64'd0);
    reply(32'h110);
    take_one(1'b1, "R9 across line edge");
  endtask

  // R6: release rule
  task automatic t_release();
    pc = 32'h124;
    tick();
    check("R6 pc line reserved", {63'd0, fetch_ok}, 64'd0);
    pc = 32'h114;
    tick();
    check("R6 newer line frees oldest", {63'd0, fetch_ok}, 64'd1);
    check("R3 after release", {32'd0, fetch_addr}, 64'h140);
  endtask

  // R9 R11 R7: wrap of the ring and split read
  task automatic t_wrap();
    issue_one();
    check("R2 full again", {63'd0, fetch_ok}, 64'd0);
    reply(32'h120);
    reply(32'h130);
    reply(32'h140);
    while (ra != 32'h13c) take_one(1'b1, "R9 streaming read");
    take_one(1'b1, "R9 split at ring end");
    take_one(1'b1, "R11 wrapped read");
    check("R7 modular count leaves one word", {63'd0, inst_valid}, 64'd0);
  endtask

  // R4 R5: flush with pending reply and restart offset
  task automatic t_flush();
    pc = 32'h144;
    tick();
    check("R6 release toward pc line", {63'd0, fetch_ok}, 64'd1);
    check("R3 next after wrap", {32'd0, fetch_addr}, 64'h150);
    issue_one();
    flush = 1'b1;
    pc    = 32'h208;
    tick();
    flush = 1'b0;
    check("R4 all free", {63'd0, fetch_ok}, 64'd1);
    check("R4 no inst", {63'd0, inst_valid}, 64'd0);
    check("R3 empty ring uses pc", {32'd0, fetch_addr}, 64'h200);
    reply(32'h150);
    check("R4 old reply ignored", {63'd0, inst_valid}, 64'd0);
    check("R4 R10 ring stays empty", {32'd0, fetch_addr}, 64'h200);
    issue_one();
    reply(32'h200);
    ra = 32'h208;
    take_one(1'b0, "R5 restart at pc offset");
    check("R7 single word after restart", {63'd0, inst_valid}, 64'd0);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    pc = 32'h104;
    flush = 1'b0;
    fetch_issue = 1'b0;
    ret_valid = 1'b0;
    ret_addr = '0;
    ret_data = '0;
    inst_ready = 1'b0;
    inst_is64 = 1'b0;
    ra = '0;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_fill();
    t_replies();
    t_release();
    t_wrap();
    t_flush();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule